// File: doc/BRIEF.md
# Clock Output Gating Controller

This block turns a bank of eighteen clock outputs on and off without glitches. The outputs are seven regular PCI clocks, three PCI clocks that can be made free-running, a USB and a display clock at 48 MHz, and six 66 MHz clocks. A small control-register file holds one enable bit per output. It also holds, for each free-runnable PCI clock, a bit that decides whether that clock obeys an active-low PCI stop input. The register file is written and read back through a simple byte-wide port.

The source clocks are modelled as even divisions of one system clock. Each output is a registered copy of its source clock. A per-output gate state can change only at the cycle just before the source rises, while the source is still low. A stopped output is therefore held low, and every high pulse it shows is a whole half period. The stop input is asynchronous and passes through a two-flop synchroniser before it is used.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: After reset every output runs. Readback gives 0x7F for selector 0 (regular PCI), 0xC7 for selector 1 (free-runnable PCI and 48 MHz), and 0x3F for selector 2 (66 MHz).
- R2: Selector 0 bit i (i = 0..6) enables regular PCI output i. A value of 1 runs the output and 0 holds it low.
- R3: Selector 0 bit 7 and selector 2 bits 6 and 7 always read 0, whatever is written. A write with selector 3 changes no register.
- R4: Selector 1 bit i (i = 0..2) enables free-runnable PCI output i. A value of 0 holds the output low.
- R5: Selector 1 bit 3+i sets whether free-runnable PCI output i obeys the stop input. A value of 0 means the output keeps running while stop is asserted. A value of 1 means it stops.
- R6: Selector 1 bit 6 enables the USB clock and bit 7 enables the display clock. The stop input has no effect on either.
- R7: Selector 2 bit i (i = 0..5) enables 66 MHz output i. The stop input has no effect on these outputs.
- R8: While pci_stop_n is low, every regular PCI output is held low. When it goes high again, they resume.
- R9: Every high pulse on any output lasts exactly half its source period. Every low phase lasts at least half a period, however the enables and the stop input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock from which all source clocks are divided |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Byte selector: 0 regular PCI, 1 free-runnable PCI and 48 MHz, 2 66 MHz, 3 none |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected byte |
| pci_stop_n | input | 1 | Asynchronous active-low PCI stop request |
| pci_clk | output | 7 | Gated regular PCI clocks |
| pcif_clk | output | 3 | Gated free-runnable PCI clocks |
| usb_clk | output | 1 | Gated 48 MHz USB clock |
| dot_clk | output | 1 | Gated 48 MHz display clock |
| m66_clk | output | 6 | Gated 66 MHz clocks |

## Verification
The bench changes enables and the stop input at arbitrary phases of the source clocks, including stop pulses only a few cycles long. A gate that updated outside the low phase would clip a high pulse, and the pulse-width monitor on every output would catch it. The free-runnable PCI clocks are run with mixed stop-control bits while stop is asserted. A design that swapped the meaning of the stop-control bit, or applied stop to the 48 MHz or 66 MHz outputs, would stop the wrong set of clocks. Writes of ones to reserved bits and writes through the unused selector are read back, to catch storage that keeps them.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int N_PCI  = 7;
  localparam int N_PCIF = 3;
  localparam int N_M66  = 6;

  typedef enum logic [1:0] {
    SEL_PCI  = 2'd0,
    SEL_PCIF = 2'd1,
    SEL_M66  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [7:0] RST_PCI  = 8'h7F;
  localparam logic [7:0] RST_PCIF = 8'hC7;
  localparam logic [7:0] RST_M66  = 8'h3F;
  localparam logic [7:0] KEEP_PCI = 8'h7F;
  localparam logic [7:0] KEEP_M66 = 8'h3F;

  // regular PCI: enable bit and not stopped
  function automatic logic [N_PCI-1:0] pci_run(input logic [7:0] r, input logic go);
    return r[N_PCI-1:0] & {N_PCI{go}};
  endfunction

  // free-runnable PCI: enable bit, and either free-running or not stopped
  function automatic logic [N_PCIF-1:0] pcif_run(input logic [7:0] r, input logic go);
    return r[N_PCIF-1:0] & (~r[2*N_PCIF-1:N_PCIF] | {N_PCIF{go}});
  endfunction
endpackage

// File: rtl/ckg_regs.sv
module ckg_regs
  import ckg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic [7:0] r_pci,
  output logic [7:0] r_pcif,
  output logic [7:0] r_m66,
  output logic [7:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_pci  <= RST_PCI;
      r_pcif <= RST_PCIF;
      r_m66  <= RST_M66;
    end else if (we) begin
      case (reg_sel_e'(sel))
        SEL_PCI:  r_pci  <= wdata & KEEP_PCI;
        SEL_PCIF: r_pcif <= wdata;
        SEL_M66:  r_m66  <= wdata & KEEP_M66;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(sel))
      SEL_PCI:  rdata = r_pci;
      SEL_PCIF: rdata = r_pcif;
      SEL_M66:  rdata = r_m66;
      default:  rdata = 8'h00;
    endcase
  end

  // R3
  pci_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd0) |=> (r_pci[7] == 1'b0 && r_pci[6:0] == $past(wdata[6:0])));
endmodule

// File: rtl/ckg_divider.sv
module ckg_divider #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic rise_next,
  output logic hi_next
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  assign rise_next = (cnt == CW'(DIV - 1));
  assign cnt_nxt   = rise_next ? '0 : cnt + 1'b1;
  assign hi_next   = (cnt_nxt < CW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise_next,
  input  logic hi_next,
  output logic clk_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV) + 1;

  logic g_on;
  logic g_nxt;

  // gate state only moves while the source is low, just before it rises
  assign g_nxt = rise_next ? en : g_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_on  <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      g_on  <= g_nxt;
      clk_o <= hi_next & g_nxt;
    end
  end

  logic [CW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_run <= '0;
    else if (clk_o) hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  // R9
  full_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_o) |-> (hi_run == CW'(HALF)));

  // R9
  rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> $past(rise_next));
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import ckg_pkg::*;
#(
  parameter int PCI_DIV = 8,
  parameter int M48_DIV = 6,
  parameter int M66_DIV = 4
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              pci_stop_n,
  output logic [N_PCI-1:0]  pci_clk,
  output logic [N_PCIF-1:0] pcif_clk,
  output logic              usb_clk,
  output logic              dot_clk,
  output logic [N_M66-1:0]  m66_clk
);
  logic [7:0] r_pci, r_pcif, r_m66;

  ckg_regs u_regs (
    .clk(sys_clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .r_pci(r_pci), .r_pcif(r_pcif), .r_m66(r_m66), .rdata(reg_rdata)
  );

  // two-flop synchroniser for the asynchronous stop request
  logic [1:0] stop_sync;
  logic       stop_go;
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) stop_sync <= 2'b11;
    else        stop_sync <= {stop_sync[0], pci_stop_n};
  end
  assign stop_go = stop_sync[1];

  logic [N_PCI-1:0]  en_pci;
  logic [N_PCIF-1:0] en_pcif;
  assign en_pci  = pci_run(r_pci, stop_go);
  assign en_pcif = pcif_run(r_pcif, stop_go);

  logic pci_rise, pci_hi, m48_rise, m48_hi, m66_rise, m66_hi;

  ckg_divider #(.DIV(PCI_DIV)) u_div_pci (
    .clk(sys_clk), .rst_n(rst_n), .rise_next(pci_rise), .hi_next(pci_hi));
  ckg_divider #(.DIV(M48_DIV)) u_div_m48 (
    .clk(sys_clk), .rst_n(rst_n), .rise_next(m48_rise), .hi_next(m48_hi));
  ckg_divider #(.DIV(M66_DIV)) u_div_m66 (
    .clk(sys_clk), .rst_n(rst_n), .rise_next(m66_rise), .hi_next(m66_hi));

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    ckg_gate #(.DIV(PCI_DIV)) u_gate (
      .clk(sys_clk), .rst_n(rst_n), .en(en_pci[i]),
      .rise_next(pci_rise), .hi_next(pci_hi), .clk_o(pci_clk[i]));

    // R8
    pci_stop_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $rose(pci_clk[i]) |-> $past(stop_go));
  end

  for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
    ckg_gate #(.DIV(PCI_DIV)) u_gate (
      .clk(sys_clk), .rst_n(rst_n), .en(en_pcif[i]),
      .rise_next(pci_rise), .hi_next(pci_hi), .clk_o(pcif_clk[i]));

    // R5
    pcif_stop_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $rose(pcif_clk[i]) |-> $past(stop_go || !r_pcif[N_PCIF+i]));
  end

  ckg_gate #(.DIV(M48_DIV)) u_gate_usb (
    .clk(sys_clk), .rst_n(rst_n), .en(r_pcif[6]),
    .rise_next(m48_rise), .hi_next(m48_hi), .clk_o(usb_clk));
  ckg_gate #(.DIV(M48_DIV)) u_gate_dot (
    .clk(sys_clk), .rst_n(rst_n), .en(r_pcif[7]),
    .rise_next(m48_rise), .hi_next(m48_hi), .clk_o(dot_clk));

  for (genvar i = 0; i < N_M66; i++) begin : g_m66
    ckg_gate #(.DIV(M66_DIV)) u_gate (
      .clk(sys_clk), .rst_n(rst_n), .en(r_m66[i]),
      .rise_next(m66_rise), .hi_next(m66_hi), .clk_o(m66_clk[i]));
  end
endmodule

// File: tb/clkout_gate_ctrl_test.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_test;
  localparam int PCI_DIV = 8;
  localparam int M48_DIV = 6;
  localparam int M66_DIV = 4;
  localparam int NO = 18;
  localparam int SETTLE = 40;
  localparam int WIN = 24;

  logic sys_clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic pci_stop_n = 1'b1;
  logic [6:0] pci_clk;
  logic [2:0] pcif_clk;
  logic usb_clk, dot_clk;
  logic [5:0] m66_clk;

  clkout_gate_ctrl #(.PCI_DIV(PCI_DIV), .M48_DIV(M48_DIV), .M66_DIV(M66_DIV)) uut (
    .sys_clk(sys_clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pci_stop_n(pci_stop_n),
    .pci_clk(pci_clk), .pcif_clk(pcif_clk), .usb_clk(usb_clk), .dot_clk(dot_clk),
    .m66_clk(m66_clk));

  always #5 sys_clk = ~sys_clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] sh_pci = 8'h7F, sh_pcif = 8'hC7, sh_m66 = 8'h3F;
  logic [17:0] exp_q[$];
  event go_ev, done_ev;
  int hi_run[NO], lo_run[NO], viol[NO];
  logic [17:0] prev_lvl = '0;

  function automatic logic [17:0] outs();
    return {m66_clk, dot_clk, usb_clk, pcif_clk, pci_clk};
  endfunction

  function automatic int half_of(input int k);
    if (k < 10) return PCI_DIV / 2;
    if (k < 12) return M48_DIV / 2;
    return M66_DIV / 2;
  endfunction

  function automatic logic [17:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c, input logic go);
    logic [17:0] m;
    for (int i = 0; i < 7; i++) m[i] = a[i] && go;
    for (int i = 0; i < 3; i++) m[7+i] = b[i] && (go || !b[3+i]);
    m[10] = b[6];
    m[11] = b[7];
    for (int i = 0; i < 6; i++) m[12+i] = c[i];
    return m;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge sys_clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge sys_clk);
    reg_we = 1'b0;
    case (s)
      2'd0: sh_pci = d & 8'h7F;
      2'd1: sh_pcif = d;
      2'd2: sh_m66 = d & 8'h3F;
      default: ;
    endcase
  endtask

  task automatic read_chk(input logic [1:0] s, input logic [7:0] exp, input string tag);
    @(negedge sys_clk);
    reg_sel = s;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  // driver: settle, push expected running mask, let the monitor compare
  task automatic expect_run(input string tag);
    repeat (SETTLE) @(negedge sys_clk);
    exp_q.push_back(model(sh_pci, sh_pcif, sh_m66, pci_stop_n));
    $display("scoreboard item: %s", tag);
    ->go_ev;
    @(done_ev);
  endtask

  string cur_tag = "";

  // monitor: pops expected masks and looks for rising edges in a window
  initial begin
    forever begin
      @(go_ev);
      while (exp_q.size() > 0) begin
        logic [17:0] e, seen, p, n;
        e = exp_q.pop_front();
        seen = '0;
        p = outs();
        for (int c = 0; c < WIN; c++) begin
          @(negedge sys_clk);
          n = outs();
          seen |= n & ~p;
          p = n;
        end
        check(seen == e, cur_tag, {14'd0, seen}, {14'd0, e});
      end
      ->done_ev;
    end
  end

  // pulse-width monitor on every output (R9)
  initial begin
    for (int k = 0; k < NO; k++) begin hi_run[k] = 0; lo_run[k] = 0; viol[k] = 0; end
  end
  always @(negedge sys_clk) begin
    logic [17:0] n;
    n = outs();
    for (int k = 0; k < NO; k++) begin
      if (n[k]) begin
        if (!prev_lvl[k] && rst_n && lo_run[k] < half_of(k)) viol[k]++;
        hi_run[k]++; lo_run[k] = 0;
      end else begin
        if (prev_lvl[k] && hi_run[k] != half_of(k)) viol[k]++;
        lo_run[k]++; hi_run[k] = 0;
      end
    end
    prev_lvl = n;
  end

  task automatic summary();
    for (int k = 0; k < NO; k++)
      check(viol[k] == 0, $sformatf("R9 output %0d pulse widths", k), viol[k], 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge sys_clk);
    rst_n = 1'b1;
    // R1
    read_chk(2'd0, 8'h7F, "R1 reset byte sel0");
    read_chk(2'd1, 8'hC7, "R1 reset byte sel1");
    read_chk(2'd2, 8'h3F, "R1 reset byte sel2");
    cur_tag = "R1 all outputs run after reset";
    expect_run(cur_tag);

    // R2
    write_reg(2'd0, 8'h55);
    cur_tag = "R2 regular PCI enable pattern 0x55";
    expect_run(cur_tag);
    write_reg(2'd0, 8'h2A);
    cur_tag = "R2 regular PCI enable pattern 0x2A";
    expect_run(cur_tag);

    // R3
    write_reg(2'd0, 8'hFF);
    read_chk(2'd0, 8'h7F, "R3 sel0 bit7 reads 0");
    write_reg(2'd2, 8'hFF);
    read_chk(2'd2, 8'h3F, "R3 sel2 bits 7:6 read 0");
    write_reg(2'd3, 8'h00);
    read_chk(2'd0, 8'h7F, "R3 sel3 write leaves sel0");
    read_chk(2'd1, 8'hC7, "R3 sel3 write leaves sel1");
    read_chk(2'd2, 8'h3F, "R3 sel3 write leaves sel2");

    // R7
    write_reg(2'd2, 8'h2A);
    cur_tag = "R7 66MHz enable pattern 0x2A";
    expect_run(cur_tag);

    // R4 R6
    write_reg(2'd1, 8'h05);
    cur_tag = "R4 R6 free PCI 101, USB and DOT off";
    expect_run(cur_tag);

    // R5 R8: pcif1 obeys stop, USB on, DOT off
    write_reg(2'd1, 8'h57);
    cur_tag = "R5 all free PCI run, stop released";
    expect_run(cur_tag);
    @(negedge sys_clk); pci_stop_n = 1'b0;
    cur_tag = "R8 R5 stop asserted: PCI off, free PCI1 off";
    expect_run(cur_tag);

    // R6 R7: stop has no effect on 48/66 MHz, all free PCI obey
    write_reg(2'd1, 8'hBF);
    cur_tag = "R5 R6 R7 all free PCI stopped, DOT on, 66 unaffected";
    expect_run(cur_tag);

    // short stop pulses at varied phases to stress the gates (R9)
    for (int j = 0; j < 12; j++) begin
      @(negedge sys_clk); pci_stop_n = 1'b1;
      repeat (1 + (j % 5)) @(negedge sys_clk);
      pci_stop_n = 1'b0;
      repeat (2 + (j % 7)) @(negedge sys_clk);
    end
    pci_stop_n = 1'b1;
    cur_tag = "R8 stop released, PCI resume";
    expect_run(cur_tag);

    // rapid enable toggles at varied phases (R9)
    for (int j = 0; j < 10; j++) begin
      write_reg(2'd0, (j % 2) ? 8'h7F : 8'h00);
      write_reg(2'd2, (j % 2) ? 8'h00 : 8'h3F);
      repeat (j % 3) @(negedge sys_clk);
    end
    write_reg(2'd1, 8'h3F);
    cur_tag = "R2 R7 R6 after toggling";
    expect_run(cur_tag);

    summary();
  end
endmodule